// File: doc/BRIEF.md
# Chip-Select Gated Dual-Output Command Register

This block registers a command/address bus and fans each registered bit out to two identical outputs, an A copy and a B copy, so that two groups of loads can be driven from one input bit. Every output is a flip-flop, so all outputs change only on the rising clock edge.

To save switching power, the data channels load only when the rank is addressed. If the gating enable is high and both active-low chip selects are high, the data registers keep their value. If the gating enable is low, or at least one chip select is low, the data registers load on every rising edge. The six control bits (two chip selects, two clock enables, two termination controls) are registered on every edge without gating, so the downstream devices always see a current chip-select and power state.

An active-low reset clears every register at once, without waiting for the clock, and it overrides the gating. After reset is released, the data outputs stay low until the first rising edge at which the data registers are allowed to load.

Top module: `csg_regbuf`

## Requirements
- R1: While rst_n is low, every output (data A/B, chip-select A/B, clock-enable A/B, termination A/B) is 0. Reset takes effect without a clock edge and whatever the gating inputs are.
- R2: data_a_o and data_b_o are equal at all times.
- R3: When gate_en_i is 0, data_a_o and data_b_o take the value of data_i one rising edge later, whatever cs_n_i is.
- R4: When gate_en_i is 1 and at least one bit of cs_n_i is 0, data_a_o and data_b_o take the value of data_i one rising edge later.
- R5: When gate_en_i is 1 and cs_n_i is 2'b11 at a rising edge, data_a_o and data_b_o keep their value across that edge, whatever data_i is.
- R6: On every rising edge out of reset, cs_a_o/cs_b_o take cs_n_i, cke_a_o/cke_b_o take cke_i, and odt_a_o/odt_b_o take odt_i, with no gating. The A and B copies are equal.
- R7: After reset is released, the data outputs stay 0 through every rising edge with gate_en_i=1 and cs_n_i=2'b11. They change only at the first edge at which loading is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capture on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 22 | Gated data channel inputs |
| cs_n_i | input | 2 | Active-low chip selects |
| cke_i | input | 2 | Clock-enable controls |
| odt_i | input | 2 | Termination controls |
| gate_en_i | input | 1 | Chip-select gating enable (1 = gating active) |
| data_a_o | output | 22 | Registered data, copy A |
| data_b_o | output | 22 | Registered data, copy B |
| cs_a_o | output | 2 | Registered chip selects, copy A |
| cs_b_o | output | 2 | Registered chip selects, copy B |
| cke_a_o | output | 2 | Registered clock enables, copy A |
| cke_b_o | output | 2 | Registered clock enables, copy B |
| odt_a_o | output | 2 | Registered termination, copy A |
| odt_b_o | output | 2 | Registered termination, copy B |

## Verification
The hardest case to reach is a reset that lands in the middle of a clock period while gating is holding non-zero data. It must be followed by several gated edges in which data_i keeps changing, yet the data outputs must stay at zero while the control outputs keep following their inputs. The bench forces this sequence directly. It pulls rst_n low between edges after random traffic has left non-zero data in the registers, checks the outputs before the next edge, and then releases reset with both chip selects high and random data applied. Random traffic that favours the held state also covers long stretches of gated hold, broken by single-cycle selects.

// File: rtl/csg_pkg.sv
package csg_pkg;

    localparam int DATA_W  = 22;
    localparam int NUM_CS  = 2;
    localparam int NUM_CKE = 2;
    localparam int NUM_ODT = 2;
    localparam int CTRL_W  = NUM_CS + NUM_CKE + NUM_ODT;

    typedef struct packed {
        logic [NUM_CS-1:0]  cs_n;
        logic [NUM_CKE-1:0] cke;
        logic [NUM_ODT-1:0] odt;
    } ctrl_t;

    typedef enum logic {
        LOAD_HOLD = 1'b0,
        LOAD_TAKE = 1'b1
    } load_e;

    // Data loads unless gating is active and no chip select is asserted.
    function automatic load_e load_decision(input logic gate_en,
                                            input logic [NUM_CS-1:0] cs_n);
        if (gate_en && (&cs_n))
            return LOAD_HOLD;
        return LOAD_TAKE;
    endfunction

endpackage

// File: rtl/csg_gate_ctl.sv
module csg_gate_ctl
    import csg_pkg::*;
(
    input  logic              gate_en,
    input  logic [NUM_CS-1:0] cs_n,
    output logic              load_en
);

    load_e decision;

    always_comb begin
        decision = load_decision(gate_en, cs_n);
        load_en  = (decision == LOAD_TAKE);
    end

endmodule

// File: rtl/csg_data_bank.sv
module csg_data_bank #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q_a,
    output logic [WIDTH-1:0] q_b
);

    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
        logic bit_a;
        logic bit_b;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_a <= 1'b0;
                bit_b <= 1'b0;
            end else if (load_en) begin
                bit_a <= d[ch];
                bit_b <= d[ch];
            end
        end

        assign q_a[ch] = bit_a;
        assign q_b[ch] = bit_b;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0));

    p_copy_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_a == q_b);

    p_load_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> q_a == $past(d));

    p_gated_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(q_a) && $stable(q_b)));

endmodule

// File: rtl/csg_ctrl_bank.sv
module csg_ctrl_bank
    import csg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_d,
    output ctrl_t ctrl_a,
    output ctrl_t ctrl_b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
        end else begin
            ctrl_a <= ctrl_d;
            ctrl_b <= ctrl_d;
        end
    end

    p_ctrl_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (ctrl_a == '0 && ctrl_b == '0));

    p_ctrl_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_a == $past(ctrl_d) && ctrl_b == $past(ctrl_d)));

endmodule

// File: rtl/csg_regbuf.sv
module csg_regbuf
    import csg_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     data_i,
    input  logic [NUM_CS-1:0] cs_n_i,
    input  logic [NUM_CKE-1:0] cke_i,
    input  logic [NUM_ODT-1:0] odt_i,
    input  logic              gate_en_i,
    output logic [DW-1:0]     data_a_o,
    output logic [DW-1:0]     data_b_o,
    output logic [NUM_CS-1:0] cs_a_o,
    output logic [NUM_CS-1:0] cs_b_o,
    output logic [NUM_CKE-1:0] cke_a_o,
    output logic [NUM_CKE-1:0] cke_b_o,
    output logic [NUM_ODT-1:0] odt_a_o,
    output logic [NUM_ODT-1:0] odt_b_o
);

    logic  load_en;
    ctrl_t ctrl_in;
    ctrl_t ctrl_qa;
    ctrl_t ctrl_qb;

    csg_gate_ctl u_gate (
        .gate_en (gate_en_i),
        .cs_n    (cs_n_i),
        .load_en (load_en)
    );

    csg_data_bank #(.WIDTH(DW)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d       (data_i),
        .q_a     (data_a_o),
        .q_b     (data_b_o)
    );

    always_comb begin
        ctrl_in.cs_n = cs_n_i;
        ctrl_in.cke  = cke_i;
        ctrl_in.odt  = odt_i;
    end

    csg_ctrl_bank u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_d (ctrl_in),
        .ctrl_a (ctrl_qa),
        .ctrl_b (ctrl_qb)
    );

    assign cs_a_o  = ctrl_qa.cs_n;
    assign cs_b_o  = ctrl_qb.cs_n;
    assign cke_a_o = ctrl_qa.cke;
    assign cke_b_o = ctrl_qb.cke;
    assign odt_a_o = ctrl_qa.odt;
    assign odt_b_o = ctrl_qb.odt;

    // R4: an asserted chip select opens the data path even with gating on.
    p_select_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i && !(&cs_n_i)) |=> data_a_o == $past(data_i));

endmodule

// File: tb/csg_regbuf_test.sv
module csg_regbuf_test;

    localparam int DW = 22;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] data_i;
    logic [1:0]    cs_n_i, cke_i, odt_i;
    logic          gate_en_i;
    logic [DW-1:0] data_a_o, data_b_o;
    logic [1:0]    cs_a_o, cs_b_o, cke_a_o, cke_b_o, odt_a_o, odt_b_o;

    logic [DW-1:0] exp_data;
    logic [5:0]    exp_ctrl;
    int            checks = 0;
    int            errors = 0;
    int unsigned   seed_dummy;

    always #4 clk = ~clk;

    csg_regbuf uut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .cs_n_i(cs_n_i),
        .cke_i(cke_i), .odt_i(odt_i), .gate_en_i(gate_en_i),
        .data_a_o(data_a_o), .data_b_o(data_b_o),
        .cs_a_o(cs_a_o), .cs_b_o(cs_b_o), .cke_a_o(cke_a_o),
        .cke_b_o(cke_b_o), .odt_a_o(odt_a_o), .odt_b_o(odt_b_o)
    );

    function automatic logic loads(input logic g, input logic [1:0] cs);
        return !(g && cs == 2'b11);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string dreq, input string creq);
        chk(dreq, 32'(data_a_o), 32'(exp_data));
        chk({dreq, "/R2"}, 32'(data_b_o), 32'(exp_data));
        chk(creq, 32'({cs_a_o, cke_a_o, odt_a_o}), 32'(exp_ctrl));
        chk(creq, 32'({cs_b_o, cke_b_o, odt_b_o}), 32'(exp_ctrl));
    endtask

    // Drive inputs away from the edge, clock once, update the model, check.
    task automatic step(input logic [DW-1:0] d, input logic g, input logic [1:0] cs,
                        input logic [1:0] ck, input logic [1:0] ot,
                        input string dreq, input string creq);
        data_i = d; gate_en_i = g; cs_n_i = cs; cke_i = ck; odt_i = ot;
        @(posedge clk);
        if (rst_n) begin
            if (loads(g, cs)) exp_data = d;
            exp_ctrl = {cs, ck, ot};
        end
        #2;
        check_all(dreq, creq);
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd2024);
        rst_n = 1'b0; data_i = '1; gate_en_i = 1'b0; cs_n_i = 2'b00;
        cke_i = 2'b11; odt_i = 2'b11;
        exp_data = '0; exp_ctrl = '0;
        #3;
        check_all("R1", "R1");
        @(posedge clk); #2;
        check_all("R1", "R1");

        // Release reset with gating closed: data must stay low (R7).
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++)
            step(DW'($urandom) | 22'h1, 1'b1, 2'b11, 2'($urandom), 2'($urandom), "R7", "R6");
        // R3: gating disabled loads even with both selects high.
        step(22'h2AAAAA, 1'b0, 2'b11, 2'b01, 2'b10, "R3", "R6");
        step(22'h155555, 1'b0, 2'b00, 2'b10, 2'b01, "R3", "R6");
        // R4: each single select opens the path.
        step(22'h3FFFFF, 1'b1, 2'b10, 2'b11, 2'b00, "R4", "R6");
        step(22'h012345, 1'b1, 2'b01, 2'b00, 2'b11, "R4", "R6");
        // R5: hold with changing data.
        step(22'h000000, 1'b1, 2'b11, 2'b01, 2'b01, "R5", "R6");
        step(22'h3C3C3C, 1'b1, 2'b11, 2'b10, 2'b10, "R5", "R6");

        // Random traffic biased toward the gated state.
        for (int i = 0; i < 400; i++) begin
            logic [1:0] cs;
            logic       g;
            g  = ($urandom % 4) != 0;
            cs = (($urandom % 3) == 0) ? 2'($urandom) : 2'b11;
            step(DW'($urandom), g, cs, 2'($urandom), 2'($urandom),
                 loads(g, cs) ? "R3/R4" : "R5", "R6");
        end

        // Load non-zero data, then reset mid-cycle while gated (R1).
        step(22'h0F0F0F, 1'b0, 2'b11, 2'b11, 2'b11, "R3", "R6");
        data_i = 22'h3FFFFF; gate_en_i = 1'b1; cs_n_i = 2'b11;
        rst_n = 1'b0;
        #1;
        exp_data = '0; exp_ctrl = '0;
        check_all("R1", "R1");
        @(posedge clk); #2;
        check_all("R1", "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++)
            step(DW'($urandom) | 22'h100, 1'b1, 2'b11, 2'b11, 2'($urandom), "R7", "R6");
        step(22'h2468AC, 1'b1, 2'b10, 2'b01, 2'b10, "R7", "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule